// File: doc/BRIEF.md
# Bidirectional Doorbell Mailbox

This block is a register-mapped mailbox between two agents: a host side and a management-controller side. Each agent has a simple synchronous register port. Two 32-bit word queues carry traffic from host to controller, and two more carry traffic from controller to host. Each queue is a FIFO of `DEPTH` words, 8 by default. An agent pushes a word by writing the queue's data register. The peer pops a word by reading the same offset.

Each direction has one status/control register. It holds live full and empty flags for both queues of that direction, an interrupt unmask bit for each flag, a doorbell bit and an interrupt enable bit. The sending agent rings the receiver by writing ones to the doorbell and enable bits. The receiving agent acknowledges by writing ones to clear them. Each agent has a level interrupt output. It is driven from the status register of the direction that agent receives.

Top module: `duplex_mailbox`

## Requirements
- R1: After reset every queue is empty, both status registers read 0x0500_0000 (both empty flags set), and both interrupt outputs are low.
- R2: Offsets 0x00 and 0x10 are host-to-controller queues 1 and 2. Offsets 0x20 and 0x30 are controller-to-host queues 1 and 2. A sender write pushes a word, and a receiver read returns the words of each queue in push order. The queues are independent of one another.
- R3: A queue reports full when it holds `DEPTH` words. A push into a full queue is dropped and the held words are unchanged.
- R4: A receiver read of an empty queue returns zero and leaves the queue empty.
- R5: The status register at 0x44 covers host-to-controller traffic and the one at 0x40 covers controller-to-host traffic. Bit 27 is queue 1 full, bit 26 is queue 1 empty, bit 25 is queue 2 full and bit 24 is queue 2 empty. Either agent can read both registers.
- R6: A write by the sending agent with bit 31 set sets the doorbell. With bit 30 set it sets the enable. The receiver's interrupt is then high while both are set.
- R7: A write by the receiving agent with bit 31 set clears the doorbell, and with bit 30 set clears the enable. A zero in either bit leaves that bit unchanged.
- R8: Any write to a status register loads bits 23..20: queue 1 full unmask, queue 1 empty unmask, queue 2 full unmask and queue 2 empty unmask. When both agents write the register in the same cycle, the receiver's value is kept. The bits read back in place.
- R9: The receiver's interrupt is also high while any unmasked full or empty flag of its incoming queues is set.
- R10: When the sender sets and the receiver clears the doorbell in the same cycle, the doorbell ends set.
- R11: A receiver write to a queue offset pushes nothing. A sender read of a queue offset returns zero and pops nothing.
- R12: A push and a pop of the same non-full queue in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe |
| h_wr | input | 1 | Host write (1) or read (0) |
| h_addr | input | AW | Host register offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after the access |
| h_irq | output | 1 | Host interrupt |
| c_sel | input | 1 | Controller access strobe |
| c_wr | input | 1 | Controller write (1) or read (0) |
| c_addr | input | AW | Controller register offset |
| c_wdata | input | 32 | Controller write data |
| c_rdata | output | 32 | Controller read data, valid the cycle after the access |
| c_irq | output | 1 | Controller interrupt |

## Verification
A corrupted FIFO pointer or count shows up at the receiver's data port within one read, as a word out of order, a lost word or a stale word. It also shows as a full or empty flag that disagrees with the count of pushes and pops. A wrong doorbell, enable or unmask bit shows in the status readback in the following cycle, and on the receiving interrupt output one cycle after the write that caused it. The scoreboard models each queue independently, so a push routed into the wrong queue appears as a mismatch on the next pop of either queue.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NDIR = 2;  // 0: host->ctrl, 1: ctrl->host
  localparam int unsigned NQ   = 2;
  localparam int unsigned REGW = 32;

  localparam int unsigned B_BELL = 31;
  localparam int unsigned B_EN   = 30;

  // Register offset of queue q in direction d.
  function automatic logic [7:0] queue_offset(input int d, input int q);
    return 8'((d * NQ + q) * 16);
  endfunction

  // Status register of direction d: ctrl->host at 0x40, host->ctrl at 0x44.
  function automatic logic [7:0] status_offset(input int d);
    return (d == 1) ? 8'h40 : 8'h44;
  endfunction

  // um: [3] q1 full, [2] q1 empty, [1] q2 full, [0] q2 empty
  function automatic logic [REGW-1:0] pack_status(input logic bell, input logic en,
                                                  input logic [NQ-1:0] full,
                                                  input logic [NQ-1:0] empty,
                                                  input logic [3:0] um);
    logic [REGW-1:0] w;
    w = '0;
    w[B_BELL] = bell;
    w[B_EN]   = en;
    w[27] = full[0];
    w[26] = empty[0];
    w[25] = full[1];
    w[24] = empty[1];
    w[23:20] = um;
    return w;
  endfunction

  function automatic logic flag_irq(input logic [NQ-1:0] full,
                                    input logic [NQ-1:0] empty,
                                    input logic [3:0] um);
    return (full[0] & um[3]) | (empty[0] & um[2]) |
           (full[1] & um[1]) | (empty[1] & um[0]);
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  // named events for the assertions
  logic push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> full && $stable(wr_ptr));
  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> empty && $stable(rd_ptr));
  a_r12_both: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && pop_ok |=> $stable(count));
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snd_we,
  input  logic [1:0]    snd_ctl,   // [1] bell, [0] enable
  input  logic [3:0]    snd_um,
  input  logic          rcv_we,
  input  logic [1:0]    rcv_ctl,
  input  logic [3:0]    rcv_um,
  input  logic [NQ-1:0] full,
  input  logic [NQ-1:0] empty,
  output logic [REGW-1:0] word,
  output logic          irq
);
  logic bell, en;
  logic [3:0] um;
  logic bell_set, bell_clr, en_set, en_clr;

  assign bell_set = snd_we & snd_ctl[1];
  assign bell_clr = rcv_we & rcv_ctl[1];
  assign en_set   = snd_we & snd_ctl[0];
  assign en_clr   = rcv_we & rcv_ctl[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bell <= 1'b0;
      en   <= 1'b0;
      um   <= '0;
    end else begin
      if (bell_set)      bell <= 1'b1;
      else if (bell_clr) bell <= 1'b0;
      if (en_set)        en <= 1'b1;
      else if (en_clr)   en <= 1'b0;
      if (rcv_we)        um <= rcv_um;
      else if (snd_we)   um <= snd_um;
    end
  end

  assign word = pack_status(bell, en, full, empty, um);
  assign irq  = (bell & en) | flag_irq(full, empty, um);

  a_r6_ring: assert property (@(posedge clk) disable iff (!rst_n)
    bell_set |=> bell);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bell_clr && !bell_set |=> !bell);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_we && !rcv_we |=> $stable(bell) && $stable(en) && $stable(um));
  a_r8_rcv_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_we |=> um == $past(rcv_um));
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_sel,
  input  logic            h_wr,
  input  logic [AW-1:0]   h_addr,
  input  logic [REGW-1:0] h_wdata,
  output logic [REGW-1:0] h_rdata,
  output logic            h_irq,
  input  logic            c_sel,
  input  logic            c_wr,
  input  logic [AW-1:0]   c_addr,
  input  logic [REGW-1:0] c_wdata,
  output logic [REGW-1:0] c_rdata,
  output logic            c_irq
);
  // side 0 = host, side 1 = controller; direction d is sent by side d
  logic [1:0]      s_sel, s_wr;
  logic [AW-1:0]   s_addr [2];
  logic [REGW-1:0] s_wd   [2];
  logic [REGW-1:0] r_q    [2];

  assign s_sel = {c_sel, h_sel};
  assign s_wr  = {c_wr, h_wr};
  assign s_addr[0] = h_addr;
  assign s_addr[1] = c_addr;
  assign s_wd[0]   = h_wdata;
  assign s_wd[1]   = c_wdata;

  logic [REGW-1:0] q_dout  [NDIR][NQ];
  logic [NQ-1:0]   q_full  [NDIR];
  logic [NQ-1:0]   q_empty [NDIR];
  logic [NQ-1:0]   q_push  [NDIR];
  logic [NQ-1:0]   q_pop   [NDIR];
  logic [REGW-1:0] st_word [NDIR];
  logic [NDIR-1:0] st_irq;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    for (genvar q = 0; q < NQ; q++) begin : g_q
      localparam logic [AW-1:0] OFF = AW'(queue_offset(d, q));
      assign q_push[d][q] = s_sel[d] & s_wr[d] & (s_addr[d] == OFF);
      assign q_pop[d][q]  = s_sel[1-d] & ~s_wr[1-d] & (s_addr[1-d] == OFF);

      mbx_fifo #(.DW(REGW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push[d][q]),
        .din   (s_wd[d]),
        .pop   (q_pop[d][q]),
        .dout  (q_dout[d][q]),
        .full  (q_full[d][q]),
        .empty (q_empty[d][q])
      );

      a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop[d][q] && q_empty[d][q] |=> r_q[1-d] == '0);
    end

    localparam logic [AW-1:0] SOFF = AW'(status_offset(d));
    logic snd_we, rcv_we;
    assign snd_we = s_sel[d] & s_wr[d] & (s_addr[d] == SOFF);
    assign rcv_we = s_sel[1-d] & s_wr[1-d] & (s_addr[1-d] == SOFF);

    mbx_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .snd_we  (snd_we),
      .snd_ctl (s_wd[d][B_BELL:B_EN]),
      .snd_um  (s_wd[d][23:20]),
      .rcv_we  (rcv_we),
      .rcv_ctl (s_wd[1-d][B_BELL:B_EN]),
      .rcv_um  (s_wd[1-d][23:20]),
      .full    (q_full[d]),
      .empty   (q_empty[d]),
      .word    (st_word[d]),
      .irq     (st_irq[d])
    );
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [REGW-1:0] rd_val;
    always_comb begin
      rd_val = '0;
      for (int d = 0; d < NDIR; d++) begin
        for (int q = 0; q < NQ; q++) begin
          if (d != s && s_addr[s] == AW'(queue_offset(d, q)) && !q_empty[d][q])
            rd_val = q_dout[d][q];
        end
        if (s_addr[s] == AW'(status_offset(d)))
          rd_val = st_word[d];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                     r_q[s] <= '0;
      else if (s_sel[s] && !s_wr[s])  r_q[s] <= rd_val;
    end

    a_r11_sender_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      s_sel[s] && !s_wr[s] && s_addr[s] == AW'(queue_offset(s, 0)) |=> r_q[s] == '0);
  end

  assign h_rdata = r_q[0];
  assign c_rdata = r_q[1];
  assign h_irq   = st_irq[1];
  assign c_irq   = st_irq[0];
endmodule

// File: tb/duplex_mailbox_test.sv
`timescale 1ns/1ps
module duplex_mailbox_test;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_sel = 0, h_wr = 0, c_sel = 0, c_wr = 0;
  logic [7:0] h_addr = 0, c_addr = 0;
  logic [31:0] h_wdata = 0, c_wdata = 0;
  logic [31:0] h_rdata, c_rdata;
  logic h_irq, c_irq;

  always #2 clk = ~clk;

  duplex_mailbox #(.AW(8), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .c_sel(c_sel), .c_wr(c_wr), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(c_rdata), .c_irq(c_irq)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] sb [4][$];   // expected words, index d*2+q
  logic [31:0] rd, rd2;

  function automatic logic [7:0] qoff(int d, int q); return 8'((d * 2 + q) * 16); endfunction

  function automatic logic [31:0] st(bit bell, bit en, bit f1, bit e1, bit f2, bit e2,
                                     logic [3:0] um);
    return {bell, en, 2'b00, f1, e1, f2, e2, um, 20'h0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(int side, bit we, logic [7:0] a, logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    if (side == 0) begin h_sel = 1; h_wr = we; h_addr = a; h_wdata = d; end
    else begin c_sel = 1; c_wr = we; c_addr = a; c_wdata = d; end
    @(negedge clk);
    h_sel = 0; c_sel = 0;
    r = (side == 0) ? h_rdata : c_rdata;
  endtask

  task automatic dual(bit hwe, logic [7:0] ha, logic [31:0] hd,
                      bit cwe, logic [7:0] ca, logic [31:0] cd,
                      output logic [31:0] hr, output logic [31:0] cr);
    @(negedge clk);
    h_sel = 1; h_wr = hwe; h_addr = ha; h_wdata = hd;
    c_sel = 1; c_wr = cwe; c_addr = ca; c_wdata = cd;
    @(negedge clk);
    h_sel = 0; c_sel = 0;
    hr = h_rdata; cr = c_rdata;
  endtask

  // driver: push through the sender side, record expectation if not full
  task automatic push_w(int d, int q, logic [31:0] v);
    logic [31:0] dummy;
    acc(d, 1, qoff(d, q), v, dummy);
    if (sb[d*2+q].size() < DEPTH) sb[d*2+q].push_back(v);
  endtask

  // monitor: pop through the receiver side and compare with the scoreboard
  task automatic pop_c(int d, int q, string req);
    logic [31:0] r, exp;
    acc(1 - d, 0, qoff(d, q), 32'h0, r);
    exp = (sb[d*2+q].size() > 0) ? sb[d*2+q].pop_front() : 32'h0;
    chk(req, r, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 / R5 reset state
    @(negedge clk);
    chk("R1 h_irq", {31'h0, h_irq}, 0);
    chk("R1 c_irq", {31'h0, c_irq}, 0);
    acc(0, 0, 8'h40, 0, rd); chk("R1 status 0x40", rd, 32'h0500_0000);
    acc(1, 0, 8'h44, 0, rd); chk("R1 status 0x44", rd, 32'h0500_0000);

    // R2 / R5 ordering and independence
    push_w(0, 0, 32'h1111_0001);
    push_w(0, 0, 32'h1111_0002);
    push_w(1, 1, 32'h2222_0001);
    push_w(0, 0, 32'h1111_0003);
    push_w(1, 1, 32'h2222_0002);
    acc(1, 0, 8'h44, 0, rd); chk("R5 q1 holding", rd, st(0,0,0,0,0,1,4'h0));
    acc(0, 0, 8'h40, 0, rd); chk("R5 q2 holding", rd, st(0,0,0,1,0,0,4'h0));
    pop_c(0, 0, "R2 h2c q1 order");
    pop_c(1, 1, "R2 c2h q2 order");
    pop_c(0, 0, "R2 h2c q1 order");
    pop_c(0, 0, "R2 h2c q1 order");
    pop_c(1, 1, "R2 c2h q2 order");

    // R3 / R9 fill h2c q2 with full-unmask for q2 (bit 21)
    acc(1, 1, 8'h44, 32'h0020_0000, rd);
    for (int i = 0; i < DEPTH - 1; i++) push_w(0, 1, 32'hA000_0000 + i);
    chk("R9 irq before full", {31'h0, c_irq}, 0);
    push_w(0, 1, 32'hA000_0007);
    chk("R9 irq on full", {31'h0, c_irq}, 1);
    acc(1, 0, 8'h44, 0, rd); chk("R3 full flag", rd, st(0,0,0,1,1,0,4'h2));
    push_w(0, 1, 32'hBAD0_BAD0);   // dropped
    for (int i = 0; i < DEPTH; i++) pop_c(0, 1, "R3 drain after drop");
    pop_c(0, 1, "R4 pop empty returns zero");
    acc(1, 0, 8'h44, 0, rd); chk("R4 empty again", rd, st(0,0,0,1,0,1,4'h2));
    acc(1, 1, 8'h44, 32'h0, rd);

    // R6 / R7 doorbell to host
    acc(1, 1, 8'h40, 32'hC000_0000, rd);
    chk("R6 h_irq rings", {31'h0, h_irq}, 1);
    acc(0, 0, 8'h40, 0, rd); chk("R6 bell+en", rd, st(1,1,0,1,0,1,4'h0));
    acc(0, 1, 8'h40, 32'h8000_0000, rd);
    chk("R7 h_irq cleared", {31'h0, h_irq}, 0);
    acc(0, 0, 8'h40, 0, rd); chk("R7 bell cleared", rd, st(0,1,0,1,0,1,4'h0));
    acc(0, 1, 8'h40, 32'h0, rd);
    acc(0, 0, 8'h40, 0, rd); chk("R7 zero no effect", rd, st(0,1,0,1,0,1,4'h0));
    acc(0, 1, 8'h40, 32'h4000_0000, rd);
    acc(0, 0, 8'h40, 0, rd); chk("R7 enable cleared", rd, st(0,0,0,1,0,1,4'h0));

    // R8 / R9 empty unmask for h2c q1 (bit 22)
    acc(1, 1, 8'h44, 32'h0040_0000, rd);
    chk("R9 empty unmask irq", {31'h0, c_irq}, 1);
    acc(0, 0, 8'h44, 0, rd); chk("R8 unmask readback", rd, st(0,0,0,1,0,1,4'h4));
    push_w(0, 0, 32'h5555_AAAA);
    chk("R9 irq drops when not empty", {31'h0, c_irq}, 0);
    pop_c(0, 0, "R2 single word");
    chk("R9 irq back when empty", {31'h0, c_irq}, 1);
    dual(1, 8'h44, 32'h0010_0000, 1, 8'h44, 32'h0080_0000, rd, rd2);
    acc(1, 0, 8'h44, 0, rd); chk("R8 receiver wins", rd, st(0,0,0,1,0,1,4'h8));
    acc(1, 1, 8'h44, 32'h0, rd);
    chk("R9 irq off when masked", {31'h0, c_irq}, 0);

    // R10 set beats clear
    dual(1, 8'h40, 32'h8000_0000, 1, 8'h40, 32'h8000_0000, rd, rd2);
    acc(0, 0, 8'h40, 0, rd); chk("R10 bell stays set", rd, st(1,0,0,1,0,1,4'h0));
    acc(0, 1, 8'h40, 32'h8000_0000, rd);
    acc(0, 0, 8'h40, 0, rd); chk("R7 bell cleared", rd, st(0,0,0,1,0,1,4'h0));

    // R11 wrong-side accesses
    acc(1, 1, qoff(0, 0), 32'hDEAD_BEEF, rd);
    acc(1, 0, 8'h44, 0, rd); chk("R11 receiver write no push", rd, st(0,0,0,1,0,1,4'h0));
    push_w(0, 0, 32'h7777_0001);
    acc(0, 0, qoff(0, 0), 0, rd); chk("R11 sender read zero", rd, 32'h0);
    pop_c(0, 0, "R11 word not consumed");

    // R12 simultaneous push and pop
    push_w(0, 0, 32'hC0DE_0001);
    dual(1, qoff(0, 0), 32'hC0DE_0002, 0, qoff(0, 0), 0, rd, rd2);
    sb[0].push_back(32'hC0DE_0002);
    chk("R12 pop during push", rd2, sb[0].pop_front());
    pop_c(0, 0, "R12 pushed word kept");
    acc(1, 0, 8'h44, 0, rd); chk("R12 empty after", rd, st(0,0,0,1,0,1,4'h0));

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule